// File: doc/BRIEF.md
# Correctable-Error Address Filter

This block keeps a short list of memory addresses at which correctable ECC errors have been seen. Each bus master that reports errors gets its own independent lane. A lane takes at most one error event per cycle, and the event is an address qualified by a valid strobe. In a single cycle the lane compares that address against every occupied slot of a small content-addressable store.

A repeat of an address already held is dropped without a report. A fresh address is written into a free slot, and the error-signalling module receives a one-cycle pulse. When every slot is occupied, a fresh address still produces the pulse, but it is not kept, and a sticky overflow flag is set.

Software frees a slot with a write-one-to-clear strobe and clears the overflow flag the same way. It can read back any stored address through an index/lane select.

Top module: `eccErrDedup`

## Requirements
- R1: Reset empties every slot of every lane. After reset, `fullStat`, `ovfStat` and `errPulse` are all zero.
- R2: An event whose address equals an occupied slot of its lane produces no pulse and changes no slot, including a repeat in the very next cycle.
- R3: An event with an unmatched address in a lane that has a free slot is written to the lowest-numbered free slot. That slot reads as occupied on the next cycle, and `errPulse` for the lane is high during that cycle.
- R4: An event with an unmatched address in a full lane raises `errPulse`, is not stored, and sets the lane's `ovfStat`. Every such event pulses, even when the same address repeats.
- R5: `fullStat` for a lane is 1 exactly when all of its slots are occupied.
- R6: A 1 on `clrEntry` bit `s*ENTRIES+i` for one cycle frees slot i of lane s. That deasserts `fullStat` on the next cycle.
- R7: `ovfStat` stays set until a 1 on `clrOvf` for that lane. If a clear and a new overflow fall in the same cycle, the flag stays set.
- R8: `rdAddr` shows the address held in slot `rdIdx` of lane `rdSrc`, combinationally from stored state.
- R9: `errPulse` is high for exactly one cycle per qualifying event. Back-to-back qualifying events give a pulse in each cycle.
- R10: Lanes are independent. Lane s uses `evtAddr[s*ADDR_W +: ADDR_W]`, `evtValid[s]` and its own slots, and `entryValid` bit `s*ENTRIES+i` shows slot i of lane s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | NUM_SRC | Per-lane error event strobe |
| evtAddr | input | NUM_SRC*ADDR_W | Per-lane error address |
| clrEntry | input | NUM_SRC*ENTRIES | Write-one-to-clear per slot |
| clrOvf | input | NUM_SRC | Write-one-to-clear for overflow flag |
| rdSrc | input | SRC_W | Lane selected for readback |
| rdIdx | input | IDX_W | Slot selected for readback |
| errPulse | output | NUM_SRC | One-cycle report to the error-signalling module |
| fullStat | output | NUM_SRC | All slots of the lane occupied |
| ovfStat | output | NUM_SRC | Sticky overflow flag |
| entryValid | output | NUM_SRC*ENTRIES | Occupied bit per slot |
| rdAddr | output | ADDR_W | Address in the selected slot |

## Verification
The bench fills a lane to the last slot and then sends unmatched addresses twice. A design that stored into a full lane, or that marked them as duplicates, would miss the second pulse. It frees a middle slot and expects the next new address to land there rather than at the end, so a wrong allocator order or a stale full flag shows up. It also issues an overflow clear and a new overflow in the same cycle, repeats an address in the cycle right after it was stored, and sends the same address into both lanes. These expose a clear that wins over a set, a match that lags one cycle, and slots shared between lanes.

// File: rtl/eccCamPkg.sv
package eccCamPkg;
  typedef struct packed {
    logic store;  // write evtAddr into the selected free slot
    logic raise;  // event qualifies for a report
  } camCtl_t;
endpackage

// File: rtl/eccCamData.sv
module eccCamData
  import eccCamPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  evtAddr,
  input  camCtl_t            ctl,
  input  logic [ENTRIES-1:0] wrSel,
  input  logic [ENTRIES-1:0] clrMask,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] hitVec,
  output logic [ADDR_W-1:0]  rdAddr
);
  logic [ADDR_W-1:0] entryAddr [ENTRIES];
  logic [ENTRIES-1:0] validQ;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          entryAddr[g] <= '0;
        end else if (ctl.store && wrSel[g]) begin
          entryAddr[g] <= evtAddr;
        end
      end
      assign hitVec[g] = validQ[g] && (entryAddr[g] == evtAddr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      validQ <= (validQ & ~clrMask) | (ctl.store ? wrSel : '0);
    end
  end

  assign validVec = validQ;
  assign rdAddr   = entryAddr[rdIdx];

  // R3
  store_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.store |-> ($countones(wrSel) == 1));

  // R3
  store_nohit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.store |-> (ctl.raise && (hitVec == '0)));

  // R3
  store_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.store |=> ((validVec & $past(wrSel)) != '0));
endmodule

// File: rtl/eccCamCtrl.sv
module eccCamCtrl
  import eccCamPkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic               clrOvf,
  output camCtl_t            ctl,
  output logic [ENTRIES-1:0] wrSel,
  output logic               errPulse,
  output logic               fullStat,
  output logic               ovfStat
);
  logic anyHit;
  logic haveFree;
  logic spill;

  always_comb begin
    wrSel    = '0;
    haveFree = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validVec[i] && !haveFree) begin
        wrSel[i] = 1'b1;
        haveFree = 1'b1;
      end
    end
  end

  assign anyHit    = |hitVec;
  assign ctl.raise = evtValid && !anyHit;
  assign ctl.store = ctl.raise && haveFree;
  assign spill     = ctl.raise && !haveFree;
  assign fullStat  = &validVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPulse <= 1'b0;
      ovfStat  <= 1'b0;
    end else begin
      errPulse <= ctl.raise;
      ovfStat  <= spill | (ovfStat & ~clrOvf);
    end
  end

  // R2
  hit_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && anyHit) |=> !errPulse);

  // R4
  full_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !anyHit && (&validVec)) |=> (errPulse && ovfStat));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfStat && !clrOvf) |=> ovfStat);

  // R9
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(evtValid));
endmodule

// File: rtl/eccErrDedup.sv
module eccErrDedup
  import eccCamPkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         evtValid,
  input  logic [NUM_SRC*ADDR_W-1:0]  evtAddr,
  input  logic [NUM_SRC*ENTRIES-1:0] clrEntry,
  input  logic [NUM_SRC-1:0]         clrOvf,
  input  logic [SRC_W-1:0]           rdSrc,
  input  logic [IDX_W-1:0]           rdIdx,
  output logic [NUM_SRC-1:0]         errPulse,
  output logic [NUM_SRC-1:0]         fullStat,
  output logic [NUM_SRC-1:0]         ovfStat,
  output logic [NUM_SRC*ENTRIES-1:0] entryValid,
  output logic [ADDR_W-1:0]          rdAddr
);
  logic [ADDR_W-1:0] laneRd [NUM_SRC];

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : gLane
      camCtl_t            ctl;
      logic [ENTRIES-1:0] wrSel;
      logic [ENTRIES-1:0] validVec;
      logic [ENTRIES-1:0] hitVec;

      eccCamCtrl #(.ENTRIES(ENTRIES)) i_ctrl (
        .clk      (clk),
        .rstN     (rstN),
        .evtValid (evtValid[s]),
        .validVec (validVec),
        .hitVec   (hitVec),
        .clrOvf   (clrOvf[s]),
        .ctl      (ctl),
        .wrSel    (wrSel),
        .errPulse (errPulse[s]),
        .fullStat (fullStat[s]),
        .ovfStat  (ovfStat[s])
      );

      eccCamData #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_data (
        .clk      (clk),
        .rstN     (rstN),
        .evtAddr  (evtAddr[s*ADDR_W +: ADDR_W]),
        .ctl      (ctl),
        .wrSel    (wrSel),
        .clrMask  (clrEntry[s*ENTRIES +: ENTRIES]),
        .rdIdx    (rdIdx),
        .validVec (validVec),
        .hitVec   (hitVec),
        .rdAddr   (laneRd[s])
      );

      assign entryValid[s*ENTRIES +: ENTRIES] = validVec;
    end
  endgenerate

  assign rdAddr = laneRd[rdSrc];
endmodule

// File: tb/test_eccErrDedup.sv
module test_eccErrDedup;
  localparam int NS = 2;
  localparam int NE = 16;
  localparam int AW = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NS-1:0]    evtValid = '0;
  logic [NS*AW-1:0] evtAddr = '0;
  logic [NS*NE-1:0] clrEntry = '0;
  logic [NS-1:0]    clrOvf = '0;
  logic [0:0]       rdSrc = '0;
  logic [3:0]       rdIdx = '0;
  logic [NS-1:0]    errPulse, fullStat, ovfStat;
  logic [NS*NE-1:0] entryValid;
  logic [AW-1:0]    rdAddr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  eccErrDedup #(.NUM_SRC(NS), .ENTRIES(NE), .ADDR_W(AW)) i_eccErrDedup (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtAddr(evtAddr),
    .clrEntry(clrEntry), .clrOvf(clrOvf), .rdSrc(rdSrc), .rdIdx(rdIdx),
    .errPulse(errPulse), .fullStat(fullStat), .ovfStat(ovfStat),
    .entryValid(entryValid), .rdAddr(rdAddr)
  );

  // {expected pulse, address} for lane 0
  localparam logic [32:0] VEC_TBL [0:19] = '{
    {1'b1, 32'h0800_0000}, {1'b1, 32'h0800_0040}, {1'b1, 32'h0800_0080},
    {1'b1, 32'h0800_00C0}, {1'b1, 32'h0800_0100}, {1'b1, 32'h0800_0140},
    {1'b1, 32'h0800_0180}, {1'b1, 32'h0800_01C0}, {1'b1, 32'h0800_0200},
    {1'b1, 32'h0800_0240}, {1'b1, 32'h0800_0280}, {1'b1, 32'h0800_02C0},
    {1'b1, 32'h0800_0300}, {1'b1, 32'h0800_0340}, {1'b1, 32'h0800_0380},
    {1'b1, 32'h0800_03C0}, {1'b0, 32'h0800_00C0}, {1'b1, 32'h0800_1000},
    {1'b0, 32'h0800_0000}, {1'b1, 32'h0800_1000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic evt(input int src, input logic [31:0] a);
    evtValid = '0;
    evtValid[src] = 1'b1;
    evtAddr[src*AW +: AW] = a;
    @(posedge clk); #1;
    evtValid = '0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); idle();
    rstN = 1'b1;
    idle();
    // R1 reset state
    chk("R1 valid", 64'(entryValid), 64'h0);
    chk("R1 full", 64'(fullStat), 64'h0);
    chk("R1 ovf", 64'(ovfStat), 64'h0);
    chk("R1 pulse", 64'(errPulse), 64'h0);

    // R2 R3 R4 R5 R9 table walk on lane 0
    for (int k = 0; k < 20; k++) begin
      evt(0, VEC_TBL[k][31:0]);
      chk("R2/R3/R4 pulse", 64'(errPulse[0]), 64'(VEC_TBL[k][32]));
      chk("R5 full", 64'(fullStat[0]), 64'(k >= 15));
      chk("R4 ovf", 64'(ovfStat[0]), 64'(k >= 17));
    end
    idle();
    chk("R9 pulse ends", 64'(errPulse), 64'h0);
    chk("R4 not stored", 64'(entryValid[15:0]), 64'hFFFF);
    chk("R10 lane1 full", 64'(fullStat[1]), 64'h0);
    chk("R10 lane1 ovf", 64'(ovfStat[1]), 64'h0);

    // R8 readback
    rdSrc = 1'b0; rdIdx = 4'd5; #1;
    chk("R8 slot5", 64'(rdAddr), 64'h0800_0140);
    rdIdx = 4'd15; #1;
    chk("R8 slot15", 64'(rdAddr), 64'h0800_03C0);

    // R6 free slot 5
    clrEntry[5] = 1'b1;
    idle();
    clrEntry = '0;
    chk("R6 valid", 64'(entryValid[15:0]), 64'hFFDF);
    chk("R6 full", 64'(fullStat[0]), 64'h0);
    chk("R7 ovf kept", 64'(ovfStat[0]), 64'h1);

    // R3 new address goes to lowest free slot
    evt(0, 32'h0800_2000);
    chk("R3 pulse", 64'(errPulse[0]), 64'h1);
    rdIdx = 4'd5; #1;
    chk("R3 slot5", 64'(rdAddr), 64'h0800_2000);
    chk("R5 full again", 64'(fullStat[0]), 64'h1);

    // R7 set wins over same-cycle clear
    clrOvf[0] = 1'b1;
    evt(0, 32'h0800_3000);
    clrOvf = '0;
    chk("R7 set wins", 64'(ovfStat[0]), 64'h1);
    chk("R4 pulse", 64'(errPulse[0]), 64'h1);

    // R7 clear alone
    clrOvf[0] = 1'b1;
    idle();
    clrOvf = '0;
    chk("R7 cleared", 64'(ovfStat[0]), 64'h0);
    idle();
    chk("R7 stays clear", 64'(ovfStat[0]), 64'h0);

    // R2 duplicate leaves state alone
    evt(0, 32'h0800_0000);
    chk("R2 dup pulse", 64'(errPulse[0]), 64'h0);
    chk("R2 dup ovf", 64'(ovfStat[0]), 64'h0);

    // R10 same address on lane 1
    evt(1, 32'h0800_0000);
    chk("R10 pulse", 64'(errPulse), 64'h2);
    chk("R10 valid", 64'(entryValid[31:16]), 64'h0001);
    rdSrc = 1'b1; rdIdx = 4'd0; #1;
    chk("R10 read", 64'(rdAddr), 64'h0800_0000);

    // R9 / R2 back-to-back
    evt(1, 32'h0900_0000);
    chk("R9 first", 64'(errPulse[1]), 64'h1);
    evt(1, 32'h0900_0000);
    chk("R2 next-cycle dup", 64'(errPulse[1]), 64'h0);
    evt(1, 32'h0900_0040);
    chk("R9 again", 64'(errPulse[1]), 64'h1);
    idle();
    chk("R9 single cycle", 64'(errPulse[1]), 64'h0);
    chk("R3 lane1 order", 64'(entryValid[31:16]), 64'h0007);

    // R1 reset mid-run
    rstN = 1'b0;
    idle(); idle();
    rstN = 1'b1;
    idle();
    chk("R1 valid again", 64'(entryValid), 64'h0);
    chk("R1 full again", 64'(fullStat), 64'h0);
    chk("R1 ovf again", 64'(ovfStat), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule